// File: doc/BRIEF.md
# Instruction Fetch and Next-PC Unit

This block holds the program counter of a single-cycle processor, presents the instruction word stored at the current PC, and picks the next PC on every rising clock edge. Each cycle the PC moves to the next sequential word, or to a relative branch target when control selects a branch and the ALU reports a zero result.

The instruction words are held in an internal word array. The array has a synchronous write port that is independent of the PC, so a testbench can fill it while reset is held. The read side is combinational. The instruction therefore changes in the same cycle the PC changes, and control and datapath logic can decode it before the next edge.

Top module: `ifetch_unit`

## Requirements
- R1: While `rst_n` is low the PC is 0. The reset is asynchronous, so the PC clears without waiting for a clock edge.
- R2: `instr` always equals the array word at index `pc[AW+1:2]` in the same cycle, where AW = log2(IMEM_DEPTH).
- R3: On each rising edge, when `branch_sel` and `alu_zero` are not both 1, the PC becomes PC + 4 modulo 2^32.
- R4: On a rising edge with `branch_sel` = 1 and `alu_zero` = 1, the PC becomes PC + 4 + (sign-extended `imm16` shifted left by two bits).
- R5: A branch select without a zero flag, or a zero flag without a branch select, produces the sequential PC + 4.
- R6: An immediate with bit 15 set moves the PC backwards. For example, `imm16` = 0xFFFE gives PC + 4 − 8.
- R7: On a rising edge with `wr_en` = 1, `wr_data` is stored at array index `wr_addr`. This also works while reset is held. With `wr_en` = 0 no word changes.
- R8: A PC at or beyond 4·IMEM_DEPTH aliases into the array modulo its depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| branch_sel | input | 1 | Control: the current instruction is a conditional branch |
| alu_zero | input | 1 | ALU zero flag |
| imm16 | input | 16 | Immediate field of the current instruction |
| wr_en | input | 1 | Instruction array write enable |
| wr_addr | input | AW | Word index to write |
| wr_data | input | 32 | Word to write |
| instr | output | 32 | Instruction at the current PC |
| pc | output | 32 | Current program counter |

## Verification
The bench drives both half-set branch conditions. A design that decoded the branch select as a direct mux select, ignoring zero, would jump on these and land on the wrong PC. A backward branch catches a zero-extended immediate, which would land far forward. A taken branch with a small offset catches a target added to PC rather than PC + 4, or an immediate that was not shifted left by two. A branch past the top of the array checks that fetch aliases modulo the depth. Writes during reset and writes with the enable low show whether the array honours its own enable.

// File: rtl/ifu_pkg.sv
package ifu_pkg;
  localparam int unsigned XLEN  = 32;
  localparam int unsigned IMM_W = 16;

  typedef logic [XLEN-1:0] word_t;

  // Sign-extend a branch offset and scale it from words to bytes.
  function automatic word_t branch_offset(input logic [IMM_W-1:0] imm);
    branch_offset = {{(XLEN-IMM_W-2){imm[IMM_W-1]}}, imm, 2'b00};
  endfunction
endpackage

// File: rtl/ifu_imem.sv
module ifu_imem #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_addr,
  input  ifu_pkg::word_t      wr_data,
  input  logic [AW-1:0]       rd_addr,
  output ifu_pkg::word_t      rd_data
);
  ifu_pkg::word_t mem_q [DEPTH];

  // Storage carries no reset so it can be filled while the PC is held.
  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_addr] <= wr_data;
  end

  assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/ifu_next_pc.sv
module ifu_next_pc (
  input  ifu_pkg::word_t                 pc_cur,
  input  logic                           branch_sel,
  input  logic                           alu_zero,
  input  logic [ifu_pkg::IMM_W-1:0]      imm16,
  output ifu_pkg::word_t                 pc_nxt
);
  ifu_pkg::word_t seq_pc;
  ifu_pkg::word_t tgt_pc;
  logic           take;

  always_comb begin
    seq_pc = pc_cur + 32'd4;
    tgt_pc = seq_pc + ifu_pkg::branch_offset(imm16);
    take   = branch_sel & alu_zero;
    pc_nxt = take ? tgt_pc : seq_pc;
  end
endmodule

// File: rtl/ifu_pc_reg.sv
module ifu_pc_reg (
  input  logic           clk,
  input  logic           rst_n,
  input  ifu_pkg::word_t pc_d,
  output ifu_pkg::word_t pc_q
);
  // No load enable: the register takes a new value on every edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end
endmodule

// File: rtl/ifetch_unit.sv
module ifetch_unit #(
  parameter int unsigned IMEM_DEPTH = 64,
  localparam int unsigned AW        = $clog2(IMEM_DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          branch_sel,
  input  logic          alu_zero,
  input  logic [15:0]   imm16,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [31:0]   wr_data,
  output logic [31:0]   instr,
  output logic [31:0]   pc
);
  ifu_pkg::word_t pc_next;

  ifu_pc_reg u_pc (
    .clk   (clk),
    .rst_n (rst_n),
    .pc_d  (pc_next),
    .pc_q  (pc)
  );

  ifu_next_pc u_npc (
    .pc_cur     (pc),
    .branch_sel (branch_sel),
    .alu_zero   (alu_zero),
    .imm16      (imm16),
    .pc_nxt     (pc_next)
  );

  // Word index taken from the PC, so addresses past the array alias (R8).
  ifu_imem #(.DEPTH(IMEM_DEPTH)) u_imem (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (pc[AW+1:2]),
    .rd_data (instr)
  );

  assert_reset_R1: assert property (@(posedge clk) !rst_n |=> pc == 32'd0);

  assert_seq_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !($past(branch_sel) && $past(alu_zero)) |-> pc == $past(pc) + 32'd4);

  assert_taken_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(branch_sel) && $past(alu_zero) |->
      pc == $past(pc) + 32'd4 + {{14{$past(imm16[15])}}, $past(imm16), 2'b00});

  assert_half_branch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && ($past(branch_sel) != $past(alu_zero)) |-> pc == $past(pc) + 32'd4);

  assert_word_align_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pc[1:0] == 2'b00);
endmodule

// File: tb/ifetch_unit_tb.sv
module ifetch_unit_tb;
  localparam int unsigned DEPTH  = 64;
  localparam int unsigned AW     = $clog2(DEPTH);
  localparam time         PERIOD = 10ns;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          branch_sel, alu_zero, wr_en;
  logic [15:0]   imm16;
  logic [AW-1:0] wr_addr;
  logic [31:0]   wr_data;
  logic [31:0]   instr, pc;

  logic [31:0] model [DEPTH];
  logic [31:0] exp_pc;
  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  ifetch_unit #(.IMEM_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .branch_sel(branch_sel), .alu_zero(alu_zero),
    .imm16(imm16), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .instr(instr), .pc(pc)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive at a falling edge, take one rising edge, sample at the next falling edge.
  task automatic step(input string req, input logic br, input logic z, input logic [15:0] imm,
                      input logic we, input logic [AW-1:0] wa, input logic [31:0] wd);
    branch_sel = br; alu_zero = z; imm16 = imm;
    wr_en = we; wr_addr = wa; wr_data = wd;
    @(posedge clk);
    @(negedge clk);
    if (we) model[wa] = wd;
    if (br && z) exp_pc = exp_pc + 32'd4 + {{14{imm[15]}}, imm, 2'b00};
    else         exp_pc = exp_pc + 32'd4;
    wr_en = 1'b0;
    check(req, pc, exp_pc);
    check({req, "/R2"}, instr, model[exp_pc[AW+1:2]]);
  endtask

  task automatic t_load_in_reset;
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(i); wr_data = 32'hA500_0000 | (i * 32'h0101);
      model[i] = wr_data;
      @(posedge clk);
    end
    @(negedge clk);
    wr_en = 1'b0;
    check("R1", pc, 32'd0);
    check("R7", instr, model[0]);
  endtask

  task automatic t_sequential;
    for (int i = 0; i < 5; i++) step("R3", 1'b0, 1'b0, 16'h0007, 1'b0, '0, '0);
  endtask

  task automatic t_half_branch;
    step("R5", 1'b1, 1'b0, 16'h000A, 1'b0, '0, '0);
    step("R5", 1'b0, 1'b1, 16'h000A, 1'b0, '0, '0);
  endtask

  task automatic t_taken;
    step("R4", 1'b1, 1'b1, 16'h0003, 1'b0, '0, '0);
    step("R4", 1'b1, 1'b1, 16'h0000, 1'b0, '0, '0);
  endtask

  task automatic t_backward;
    step("R6", 1'b1, 1'b1, 16'hFFFE, 1'b0, '0, '0);
    step("R6", 1'b1, 1'b1, 16'hFFFF, 1'b0, '0, '0);
  endtask

  task automatic t_alias;
    logic [31:0] tgt;
    tgt = 32'(4 * DEPTH) + 32'd8;
    step("R8", 1'b1, 1'b1, 16'((tgt - (exp_pc + 32'd4)) >> 2), 1'b0, '0, '0);
    check("R8", instr, model[2]);
  endtask

  task automatic t_write;
    logic [AW-1:0] nxt;
    nxt = AW'((exp_pc + 32'd4) >> 2);
    step("R7", 1'b0, 1'b0, 16'h0, 1'b1, nxt, 32'hDEAD_BEEF);
    check("R7", instr, 32'hDEAD_BEEF);
    nxt = AW'((exp_pc + 32'd4) >> 2);
    branch_sel = 1'b0; alu_zero = 1'b0;
    wr_en = 1'b0; wr_addr = nxt; wr_data = 32'h0BAD_0BAD;
    @(posedge clk);
    @(negedge clk);
    exp_pc = exp_pc + 32'd4;
    check("R7", pc, exp_pc);
    check("R7", instr, model[nxt]);
  endtask

  task automatic t_async_reset;
    #(PERIOD/4);
    rst_n = 1'b0;
    #1;
    check("R1", pc, 32'd0);
    check("R1", instr, model[0]);
  endtask

  initial begin
    rst_n = 1'b1; branch_sel = 1'b0; alu_zero = 1'b0; imm16 = '0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    #1 rst_n = 1'b0;
    t_load_in_reset();
    @(negedge clk);
    check("R1", pc, 32'd0);
    rst_n  = 1'b1;
    exp_pc = 32'd0;
    t_sequential();
    t_half_branch();
    t_taken();
    t_backward();
    t_alias();
    t_write();
    t_async_reset();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule